// File: doc/BRIEF.md
# Dual Block CRC Generator and Checker

This block protects a framed data link built from fixed blocks of twelve bytes with two cyclic redundancy checks. A 16-bit check guards each header block on its own. A 32-bit check spans a whole message. It runs over every byte of each intermediate block and over the leading eight bytes of the last block. Bytes arrive one per valid cycle with a block-start marker and a block-type tag. In transmit mode the block passes data through and puts the computed check bytes in place of the check field. In receive mode it compares the received check field and raises a one-cycle pass/fail strobe.

Seeding of the 32-bit accumulator is tied to a task-completion strobe. It reseeds after most tasks, but not after the tasks that move the intermediate and last blocks of a message. Receive and transmit use different exemption lists. A single select bit decides whether both accumulators start from all ones or all zeros.

Top module: `dual_crc_engine`

## Requirements
- R1: The short check uses generator x^16+x^12+x^5+1 with no bit reflection and no final inversion. Bits of each byte enter most significant first. It covers bytes 0 to 9 of a header block (block_kind 0) and is reseeded on byte 0 of every header.
- R2: In transmit mode every accepted byte appears on out_byte with out_valid one cycle later. In a header, bytes 10 and 11 are replaced by the short check, high byte first, and out_check is set for them.
- R3: The long check uses generator 0x04C11DB7 (x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1), most significant bit first, with no reflection and no final inversion. It covers all twelve bytes of each intermediate block (block_kind 1) and bytes 0 to 7 of the last block (block_kind 2). Header bytes do not touch it.
- R4: In transmit mode, bytes 8 to 11 of a last block are replaced by the long check, most significant byte first, with out_check set.
- R5: With seed_zero at 0 both accumulators are seeded to all ones. With seed_zero at 1 they are seeded to all zeros. The value is sampled at the cycle of each reset or reseed.
- R6: In receive mode, check_stb pulses for one cycle after byte 11 of a header or last block. check_ok is 1 only if every check byte of that block matched. check_long is 1 for a last block and 0 for a header. No strobe occurs in transmit mode.
- R7: In receive mode (tx_mode 0), a task_done pulse reseeds the long check unless task_code is 0 (null) or 3 (receive intermediate or last block).
- R8: In transmit mode (tx_mode 1), a task_done pulse reseeds the long check unless task_code is 0 (null), 1 (transmit intermediate block) or 2 (transmit last block).
- R9: When a reseed coincides with a long-check data byte, the reseed wins and that byte is not accumulated.
- R10: A byte beyond the twelfth of a block, or any byte of a block with block_kind 3, passes through unchanged in transmit mode. It changes neither check and raises no strobe.
- R11: A synchronous active-high reset clears out_valid, out_check and check_stb and seeds both accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seed_zero | input | 1 | Seed select: 0 all ones, 1 all zeros |
| tx_mode | input | 1 | 1 transmit, 0 receive |
| byte_valid | input | 1 | A byte is presented this cycle |
| block_start | input | 1 | Marks byte 0 of a block (with byte_valid) |
| block_kind | input | 2 | 0 header, 1 intermediate, 2 last, 3 other |
| byte_in | input | 8 | Data byte |
| task_done | input | 1 | Task-completion pulse |
| task_code | input | 3 | Code of the completed task |
| out_valid | output | 1 | Transmit byte valid |
| out_byte | output | 8 | Transmit byte (data or check) |
| out_check | output | 1 | Current out_byte is a check byte |
| check_stb | output | 1 | Receive check verdict strobe |
| check_ok | output | 1 | Verdict: all check bytes matched |
| check_long | output | 1 | Verdict belongs to the long check |

## Verification
The assertions rely on each block being opened by block_start together with byte_valid. They also assume tx_mode and seed_zero stay steady across a block, and that no more than one byte arrives per cycle. The stimulus changes mode and seed only between blocks or under reset. Every block it sends starts with block_start. A coincident task_done and data byte is sent only in the one sequence written for that case. Extra bytes past twelve are sent without a new start marker to reach the overrun path.

// File: rtl/dcrc_pkg.sv
package dcrc_pkg;

    typedef enum logic [1:0] {
        BLK_HEADER = 2'd0,
        BLK_INTER  = 2'd1,
        BLK_LAST   = 2'd2,
        BLK_OTHER  = 2'd3
    } blk_kind_e;

    typedef enum logic [2:0] {
        ROLE_NONE       = 3'd0,
        ROLE_SHORT_DATA = 3'd1,
        ROLE_SHORT_CHK  = 3'd2,
        ROLE_LONG_DATA  = 3'd3,
        ROLE_LONG_CHK   = 3'd4
    } byte_role_e;

    localparam logic [2:0] TASK_NULL     = 3'd0;
    localparam logic [2:0] TASK_TX_INTER = 3'd1;
    localparam logic [2:0] TASK_TX_LAST  = 3'd2;
    localparam logic [2:0] TASK_RX_BLOCK = 3'd3;

    // Whether a completed task restarts the message-wide accumulator.
    function automatic logic long_reseed(input logic tx, input logic [2:0] code);
        logic keep;
        if (tx) keep = (code == TASK_NULL) || (code == TASK_TX_INTER) || (code == TASK_TX_LAST);
        else    keep = (code == TASK_NULL) || (code == TASK_RX_BLOCK);
        return !keep;
    endfunction

endpackage

// File: rtl/dcrc_accum.sv
module dcrc_accum #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         seed_zero,
    input  logic         clear,
    input  logic         feed,
    input  logic [7:0]   data,
    output logic [W-1:0] crc
);

    typedef struct packed {
        logic [W-1:0] crc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [W-1:0] seed_val;
    logic [W-1:0] base;

    function automatic logic [W-1:0] shift_byte(input logic [W-1:0] c, input logic [7:0] d);
        logic [W-1:0] r;
        logic         fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[W-1] ^ d[i];
            r  = {r[W-2:0], 1'b0};
            if (fb) r = r ^ POLY;
        end
        return r;
    endfunction

    always_comb begin
        seed_val = seed_zero ? '0 : '1;
        base     = clear ? seed_val : st_q.crc;
        st_d     = st_q;
        st_d.crc = feed ? shift_byte(base, data) : base;
        if (rst) st_d.crc = seed_val;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign crc = st_q.crc;

    // R5
    seed_value_chk: assert property (@(posedge clk) disable iff (rst)
        (clear && !feed) |=> (crc == ($past(seed_zero) ? '0 : '1)));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !feed) |=> $stable(crc));

endmodule

// File: rtl/dcrc_framer.sv
module dcrc_framer
    import dcrc_pkg::*;
#(
    parameter int BLOCK_BYTES = 12,
    parameter int SHORT_DATA  = 10,
    parameter int LONG_DATA   = 8,
    parameter int IDX_W       = $clog2(BLOCK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic             block_start,
    input  logic [1:0]       block_kind,
    output byte_role_e       role,
    output logic [IDX_W-1:0] chk_pos,
    output logic             chk_final,
    output logic             blk_first
);

    localparam logic [IDX_W-1:0] IDX_END   = IDX_W'(BLOCK_BYTES);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(BLOCK_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(SHORT_DATA);
    localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(LONG_DATA);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        blk_kind_e        kind;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [IDX_W-1:0] cur_idx;
    blk_kind_e        cur_kind;

    always_comb begin
        st_d      = st_q;
        role      = ROLE_NONE;
        chk_pos   = '0;
        chk_final = 1'b0;
        cur_idx   = st_q.idx;
        cur_kind  = st_q.kind;
        if (byte_valid && block_start) begin
            cur_idx  = '0;
            cur_kind = blk_kind_e'(block_kind);
        end
        blk_first = byte_valid && (cur_idx == '0);
        if (byte_valid && (cur_idx < IDX_END)) begin
            unique case (cur_kind)
                BLK_HEADER: begin
                    if (cur_idx < IDX_SHORT) role = ROLE_SHORT_DATA;
                    else begin
                        role    = ROLE_SHORT_CHK;
                        chk_pos = cur_idx - IDX_SHORT;
                    end
                end
                BLK_INTER: role = ROLE_LONG_DATA;
                BLK_LAST: begin
                    if (cur_idx < IDX_LONG) role = ROLE_LONG_DATA;
                    else begin
                        role    = ROLE_LONG_CHK;
                        chk_pos = cur_idx - IDX_LONG;
                    end
                end
                default: role = ROLE_NONE;
            endcase
            chk_final = ((role == ROLE_SHORT_CHK) || (role == ROLE_LONG_CHK)) && (cur_idx == IDX_LAST);
            st_d.idx  = cur_idx + 1'b1;
            st_d.kind = cur_kind;
        end
        if (rst) begin
            st_d.idx  = IDX_END;
            st_d.kind = BLK_OTHER;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R10
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.idx <= IDX_END);

endmodule

// File: rtl/dual_crc_engine.sv
module dual_crc_engine
    import dcrc_pkg::*;
#(
    parameter int              BLOCK_BYTES = 12,
    parameter int              SHORT_DATA  = 10,
    parameter int              LONG_DATA   = 8,
    parameter int              SHORT_W     = 16,
    parameter int              LONG_W      = 32,
    parameter logic [15:0]     SHORT_POLY  = 16'h1021,
    parameter logic [31:0]     LONG_POLY   = 32'h04C1_1DB7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       seed_zero,
    input  logic       tx_mode,
    input  logic       byte_valid,
    input  logic       block_start,
    input  logic [1:0] block_kind,
    input  logic [7:0] byte_in,
    input  logic       task_done,
    input  logic [2:0] task_code,
    output logic       out_valid,
    output logic [7:0] out_byte,
    output logic       out_check,
    output logic       check_stb,
    output logic       check_ok,
    output logic       check_long
);

    localparam int IDX_W     = $clog2(BLOCK_BYTES + 1);
    localparam int SHORT_CHK = BLOCK_BYTES - SHORT_DATA;
    localparam int LONG_CHK  = BLOCK_BYTES - LONG_DATA;

    typedef struct packed {
        logic       ov;
        logic [7:0] ob;
        logic       oc;
        logic       mis;
        logic       stb;
        logic       ok;
        logic       lng;
    } eng_st_t;

    eng_st_t          st_d, st_q;
    byte_role_e       role;
    logic [IDX_W-1:0] chk_pos;
    logic             chk_final;
    logic             blk_first;
    logic [SHORT_W-1:0] short_crc;
    logic [LONG_W-1:0]  long_crc;
    logic             long_clear, long_feed, short_clear, short_feed;
    logic             is_chk, byte_bad;
    logic [7:0]       exp_byte;
    int               sidx, lidx;

    dcrc_framer #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .SHORT_DATA  (SHORT_DATA),
        .LONG_DATA   (LONG_DATA),
        .IDX_W       (IDX_W)
    ) u_framer (
        .clk         (clk),
        .rst         (rst),
        .byte_valid  (byte_valid),
        .block_start (block_start),
        .block_kind  (block_kind),
        .role        (role),
        .chk_pos     (chk_pos),
        .chk_final   (chk_final),
        .blk_first   (blk_first)
    );

    assign short_feed  = (role == ROLE_SHORT_DATA);
    assign short_clear = short_feed && blk_first;
    assign long_clear  = task_done && long_reseed(tx_mode, task_code);
    assign long_feed   = (role == ROLE_LONG_DATA) && !long_clear;

    dcrc_accum #(.W(SHORT_W), .POLY(SHORT_POLY)) u_short (
        .clk       (clk),
        .rst       (rst),
        .seed_zero (seed_zero),
        .clear     (short_clear),
        .feed      (short_feed),
        .data      (byte_in),
        .crc       (short_crc)
    );

    dcrc_accum #(.W(LONG_W), .POLY(LONG_POLY)) u_long (
        .clk       (clk),
        .rst       (rst),
        .seed_zero (seed_zero),
        .clear     (long_clear),
        .feed      (long_feed),
        .data      (byte_in),
        .crc       (long_crc)
    );

    always_comb begin
        st_d     = st_q;
        is_chk   = (role == ROLE_SHORT_CHK) || (role == ROLE_LONG_CHK);
        exp_byte = '0;
        sidx     = 0;
        lidx     = 0;
        if (role == ROLE_SHORT_CHK) begin
            sidx     = 8 * (SHORT_CHK - 1 - int'(chk_pos));
            exp_byte = short_crc[sidx +: 8];
        end else if (role == ROLE_LONG_CHK) begin
            lidx     = 8 * (LONG_CHK - 1 - int'(chk_pos));
            exp_byte = long_crc[lidx +: 8];
        end
        byte_bad = (byte_in != exp_byte);

        st_d.ov  = byte_valid && tx_mode;
        st_d.ob  = (tx_mode && is_chk) ? exp_byte : byte_in;
        st_d.oc  = byte_valid && tx_mode && is_chk;
        st_d.stb = 1'b0;
        st_d.ok  = 1'b0;
        st_d.lng = 1'b0;
        if (is_chk && !tx_mode) begin
            st_d.mis = (chk_pos == '0) ? byte_bad : (st_q.mis | byte_bad);
            if (chk_final) begin
                st_d.stb = 1'b1;
                st_d.ok  = !st_d.mis;
                st_d.lng = (role == ROLE_LONG_CHK);
            end
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_valid  = st_q.ov;
    assign out_byte   = st_q.ob;
    assign out_check  = st_q.oc;
    assign check_stb  = st_q.stb;
    assign check_ok   = st_q.ok;
    assign check_long = st_q.lng;

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        check_stb |=> !check_stb);

    // R6
    stb_rx_only_chk: assert property (@(posedge clk) disable iff (rst)
        check_stb |-> !$past(tx_mode));

    // R2
    out_follows_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(byte_valid));

    // R11
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_check && !check_stb));

endmodule

// File: tb/dual_crc_engine_test.sv
module dual_crc_engine_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       seed_zero = 1'b0;
    logic       tx_mode = 1'b1;
    logic       byte_valid = 1'b0;
    logic       block_start = 1'b0;
    logic [1:0] block_kind = 2'd3;
    logic [7:0] byte_in = 8'h00;
    logic       task_done = 1'b0;
    logic [2:0] task_code = 3'd0;
    logic       out_valid, out_check, check_stb, check_ok, check_long;
    logic [7:0] out_byte;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;
    string scen = "R11";

    // reference model state
    logic [15:0] m16;
    logic [31:0] m32;
    int          midx = 12;
    int          mkind = 3;
    bit          mmis = 0;
    bit          e_ov, e_oc, e_stb, e_ok, e_lng;
    logic [7:0]  e_ob;
    string       e_tag;

    always #10 clk = ~clk;

    dual_crc_engine uut (
        .clk(clk), .rst(rst), .seed_zero(seed_zero), .tx_mode(tx_mode),
        .byte_valid(byte_valid), .block_start(block_start), .block_kind(block_kind),
        .byte_in(byte_in), .task_done(task_done), .task_code(task_code),
        .out_valid(out_valid), .out_byte(out_byte), .out_check(out_check),
        .check_stb(check_stb), .check_ok(check_ok), .check_long(check_long)
    );

    function automatic logic [31:0] ref_upd(logic [31:0] c, logic [7:0] d, int w, logic [31:0] poly);
        logic [31:0] r = c;
        for (int b = 0; b < 8; b++) begin
            bit top = r[w-1] ^ d[7-b];
            r = r << 1;
            if (w < 32) r = r & ((32'd1 << w) - 1);
            if (top) r = r ^ poly;
        end
        return r;
    endfunction

    function automatic int role_of(int kind, int idx);
        if (idx >= 12) return 0;
        case (kind)
            0: return (idx < 10) ? 1 : 2;
            1: return 3;
            2: return (idx < 8) ? 3 : 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] ref_chk(int kind, int idx);
        int r = role_of(kind, idx);
        if (r == 2) return 8'(m16 >> (8 * (1 - (idx - 10))));
        if (r == 4) return 8'(m32 >> (8 * (3 - (idx - 8))));
        return 8'h00;
    endfunction

    task automatic model;
        bit lclr;
        int r;
        logic [7:0] cb;
        e_ov = 0; e_ob = 0; e_oc = 0; e_stb = 0; e_ok = 0; e_lng = 0; e_tag = "R10";
        if (rst) begin
            m16 = seed_zero ? 16'h0 : 16'hFFFF;
            m32 = seed_zero ? 32'h0 : 32'hFFFF_FFFF;
            midx = 12; mkind = 3; mmis = 0; e_tag = "R11";
            return;
        end
        if (tx_mode) lclr = task_done && !(task_code inside {3'd0, 3'd1, 3'd2});
        else         lclr = task_done && !(task_code inside {3'd0, 3'd3});
        if (byte_valid) begin
            if (block_start) begin midx = 0; mkind = int'(block_kind); end
            r  = role_of(mkind, midx);
            cb = ref_chk(mkind, midx);
            e_tag = (r == 1) ? "R1" : (r == 2) ? "R2" : (r == 3) ? "R3" : (r == 4) ? "R4" : "R10";
            if (tx_mode) begin
                e_ov = 1;
                e_oc = (r == 2 || r == 4);
                e_ob = e_oc ? cb : byte_in;
            end else if (r == 2 || r == 4) begin
                if ((r == 2 && midx == 10) || (r == 4 && midx == 8)) mmis = (byte_in != cb);
                else mmis = mmis | (byte_in != cb);
                if (midx == 11) begin
                    e_stb = 1; e_ok = !mmis; e_lng = (r == 4); e_tag = "R6";
                end
            end
            if (r == 1) begin
                if (midx == 0) m16 = seed_zero ? 16'h0 : 16'hFFFF;
                m16 = 16'(ref_upd({16'h0, m16}, byte_in, 16, 32'h1021));
            end
            if (r == 3 && !lclr) m32 = ref_upd(m32, byte_in, 32, 32'h04C1_1DB7);
            if (midx < 12) midx++;
        end
        if (lclr) m32 = seed_zero ? 32'h0 : 32'hFFFF_FFFF;
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s/%s %s: actual %h expected %h at cycle %0d", scen, e_tag, what, act, exp, cycles);
        end
    endtask

    // drive inputs already set, advance one cycle, compare registered outputs
    task automatic tick;
        model();
        @(posedge clk);
        @(negedge clk);
        chk("out_valid", 32'(out_valid), 32'(e_ov));
        chk("check_stb", 32'(check_stb), 32'(e_stb));
        if (e_ov) begin
            chk("out_byte", 32'(out_byte), 32'(e_ob));
            chk("out_check", 32'(out_check), 32'(e_oc));
        end
        if (e_stb) begin
            chk("check_ok", 32'(check_ok), 32'(e_ok));
            chk("check_long", 32'(check_long), 32'(e_lng));
        end
        byte_valid = 0; block_start = 0; task_done = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_task(int code);
        task_done = 1; task_code = 3'(code);
        tick();
    endtask

    // send one 12-byte block; in receive mode the check field is filled correctly
    // from the model unless bad_at selects a byte to corrupt
    task automatic send_block(int kind, int base, int bad_at);
        for (int i = 0; i < 12; i++) begin
            int r = role_of(kind, i);
            byte_valid  = 1;
            block_start = (i == 0);
            block_kind  = 2'(kind);
            byte_in     = 8'(base + 37 * i);
            if (!tx_mode && (r == 2 || r == 4)) byte_in = ref_chk(kind, i);
            if (i == bad_at) byte_in = byte_in ^ 8'h5A;
            tick();
        end
    endtask

    task automatic do_reset;
        rst = 1;
        tick();
        rst = 0;
    endtask

    initial begin
        @(negedge clk);
        // R11: reset state
        scen = "R11";
        do_reset();
        idle(2);

        // R1 R2: transmit header, seeded with ones
        scen = "R1";
        send_block(0, 8'h10, -1);
        send_block(0, 8'hC3, -1);
        idle(1);

        // R5: zero seed across header and message
        scen = "R5";
        seed_zero = 1;
        do_reset();
        send_block(0, 8'h01, -1);
        send_block(1, 8'h44, -1);
        send_block(2, 8'h90, -1);
        finish_task(5);
        send_block(2, 8'h00, -1);
        seed_zero = 0;

        // R3 R4: multi-block message with exempt task codes in between
        scen = "R3";
        finish_task(4);
        send_block(0, 8'h22, -1);
        send_block(1, 8'h31, -1);
        finish_task(1);
        send_block(1, 8'h7E, -1);
        finish_task(2);
        finish_task(0);
        send_block(2, 8'hA5, -1);
        idle(1);

        // R8: transmit reseed rules
        scen = "R8";
        send_block(1, 8'h12, -1);
        finish_task(6);
        send_block(2, 8'h55, -1);
        send_block(1, 8'h19, -1);
        finish_task(3);
        send_block(2, 8'h56, -1);

        // R6: receive header and last, good and corrupted
        scen = "R6";
        tx_mode = 0;
        finish_task(7);
        send_block(0, 8'h08, -1);
        send_block(0, 8'h09, 11);
        send_block(0, 8'h0A, 10);
        send_block(0, 8'h0B, 3);
        send_block(1, 8'h61, -1);
        send_block(2, 8'h62, -1);
        finish_task(4);
        send_block(1, 8'h63, -1);
        send_block(2, 8'h64, 9);
        finish_task(4);
        send_block(2, 8'h65, 2);
        tx_mode = 1;
        send_block(0, 8'h66, -1);
        tx_mode = 0;

        // R7: receive reseed rules
        scen = "R7";
        finish_task(5);
        send_block(1, 8'h70, -1);
        finish_task(3);
        finish_task(0);
        send_block(2, 8'h71, -1);
        send_block(1, 8'h72, -1);
        finish_task(1);
        send_block(2, 8'h73, -1);
        send_block(1, 8'h74, -1);
        finish_task(2);
        send_block(2, 8'h75, -1);

        // R9: reseed coincident with a long data byte
        scen = "R9";
        tx_mode = 1;
        finish_task(4);
        byte_valid = 1; block_start = 1; block_kind = 2'd1; byte_in = 8'hEE;
        task_done = 1; task_code = 3'd5;
        tick();
        for (int i = 1; i < 12; i++) begin
            byte_valid = 1; block_kind = 2'd1; byte_in = 8'(i * 11);
            if (i == 6) begin task_done = 1; task_code = 3'd4; end
            tick();
        end
        send_block(2, 8'h3C, -1);

        // R10: overrun bytes and kind 3 blocks
        scen = "R10";
        for (int i = 0; i < 3; i++) begin
            byte_valid = 1; byte_in = 8'(8'hD0 + i);
            tick();
        end
        send_block(3, 8'h81, -1);
        send_block(2, 8'h82, -1);
        tx_mode = 0;
        send_block(3, 8'h83, -1);
        for (int i = 0; i < 2; i++) begin
            byte_valid = 1; byte_in = 8'hFF;
            tick();
        end
        send_block(2, 8'h84, -1);
        idle(2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule